// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a small bank of general-purpose input pins and turns their transitions into interrupts for a processor. Each pin first passes through a synchroniser. Every low-to-high and high-to-low transition is then recorded at all times, in two independent flag sets: one for rising events and one for falling events. A per-pin trigger field chooses which of the two flags software sees in the status register. The same choice decides whether that pin may drive the single parent interrupt line.

Software reaches the block through a plain register port. The port has a write strobe, an address and write data, and the read data is a combinational function of the address. Writing ones to the status register clears both the rising and the falling flag of each selected pin, whatever its trigger is set to. This lets software emulate a both-edge interrupt. After a clear it re-reads the pin level and flips the trigger. An edge that arrives between the clear and the trigger change is still held, so the interrupt shows up as soon as the matching trigger is chosen.

Register map (2-bit address):

| Address | Access | Contents |
|---|---|---|
| 0 | read only | synchronised pin levels |
| 1 | read/write | trigger fields |
| 2 | read / write-one-to-clear | visible status |
| 3 | read only | reads as zero |

Top module: `gio_edge_irq`

## Requirements
- R1: After reset, every flag, the trigger register, all status bits and the interrupt line read as zero.
- R2: Address 0 returns the pin levels in bits [7:0], with bits [15:8] reading as zero. A pin change that is set up before clock edge k shows up in this register after edge k+1 (two synchroniser stages).
- R3: A rising transition of a synchronised pin sets that pin's rising flag. This happens whatever the trigger field holds.
- R4: A falling transition of a synchronised pin sets that pin's falling flag. This happens whatever the trigger field holds.
- R5: Pin i's trigger field sits at bits [2i+1:2i] of address 1. The codes are: 00 = none, 01 = falling, 10 = rising, 11 = none. Status bit i at address 2 shows the rising flag under code 10 and the falling flag under code 01. Under the other two codes it shows 0.
- R6: Writing address 2 clears both the rising and the falling flag of every pin whose data bit is 1. Pins whose data bit is 0 keep their flags.
- R7: Suppose a new edge on a pin is detected in the same cycle as a clear write for that pin. The flag for that edge stays set. The opposite flag is cleared.
- R8: The interrupt output is active high. It equals the OR of all visible status bits, registered once, so it rises one cycle after the status bit first becomes visible.
- R9: An edge latched while its trigger is off becomes visible, and raises the interrupt, as soon as the matching trigger code is written. No new edge is needed.
- R10: The trigger register reads back the value last written to address 1. Writes to address 0 or address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | 8 | Asynchronous GPIO input pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational in the address |
| irq_o | output | 1 | Parent interrupt line, active high |

## Verification
The hardest situation to reach from the ports is a new edge meeting a clear write in the very same cycle. The edge must be counted through both synchroniser stages. The bench changes the pin just before clock edge k, raises the clear write just before edge k+2, and then reads the status under both trigger codes. A second hard case is an edge latched while the trigger is off. The bench sweeps every pin, every trigger code and both edge directions, and then switches to the matching code to show the event was kept.

// File: rtl/gio_pkg.sv
package gio_pkg;
  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_RSVD = 2'b11
  } trig_e;

  typedef enum logic [1:0] {
    RA_LEVEL = 2'd0,
    RA_TRIG  = 2'd1,
    RA_STAT  = 2'd2,
    RA_SPARE = 2'd3
  } reg_addr_e;

  localparam int TRIG_W = 2;
endpackage

// File: rtl/gio_sync_edge.sv
module gio_sync_edge #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][N-1:0] chain_q;
  logic [N-1:0]             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[LAST];
    end
  end

  assign level_o = chain_q[LAST];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  // cycles since reset, saturating, so the latency check never looks into reset
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_lat_chk
      // R2: level equals the pin value sampled two edges earlier
      a_r2_sync_latency: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 2'd2) |-> (level_o == $past(pin_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/gio_edge_latch.sv
module gio_edge_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rise_ev_i,
  input  logic [N-1:0] fall_ev_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] rise_q,
  output logic [N-1:0] fall_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      // a fresh edge overrides a simultaneous clear
      rise_q <= (rise_q & ~clr_i) | rise_ev_i;
      fall_q <= (fall_q & ~clr_i) | fall_ev_i;
    end
  end

  // R6: a clear without a competing edge leaves both flags empty
  a_r6_clear_both: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((rise_q | fall_q) & $past(clr_i & ~rise_ev_i & ~fall_ev_i)) == '0));

  // R7: a detected edge is always held in the next cycle, clear or not
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(rise_ev_i) & ~rise_q) | ($past(fall_ev_i) & ~fall_q)) == '0));
endmodule

// File: rtl/gio_trig_view.sv
module gio_trig_view
  import gio_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [N*TRIG_W-1:0] cfg_wdata,
  input  logic [N-1:0]        rise_q,
  input  logic [N-1:0]        fall_q,
  output logic [N*TRIG_W-1:0] cfg_q,
  output logic [N-1:0]        vis_o,
  output logic                irq_q
);
  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      trig_e code;
      assign code     = trig_e'(cfg_q[TRIG_W*i +: TRIG_W]);
      assign vis_o[i] = ((code == TRIG_RISE) && rise_q[i]) ||
                        ((code == TRIG_FALL) && fall_q[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |vis_o;
  end

  // R10: the trigger register only moves on a write to it
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_q));
endmodule

// File: rtl/gio_edge_irq.sv
module gio_edge_irq
  import gio_pkg::*;
#(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_i,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [2*N-1:0]    reg_wdata,
  output logic [2*N-1:0]    reg_rdata,
  output logic              irq_o
);
  localparam int DW = N * TRIG_W;

  logic [N-1:0]  level, rise_ev, fall_ev, rise_q, fall_q, vis, clr;
  logic [DW-1:0] cfg_q;
  logic          cfg_we;
  reg_addr_e     ra;

  assign ra     = reg_addr_e'(reg_addr);
  assign cfg_we = reg_we && (ra == RA_TRIG);
  assign clr    = (reg_we && (ra == RA_STAT)) ? reg_wdata[N-1:0] : '0;

  gio_sync_edge #(.N(N), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i),
    .level_o(level), .rise_o(rise_ev), .fall_o(fall_ev)
  );

  gio_edge_latch #(.N(N)) u_latch (
    .clk(clk), .rst(rst), .rise_ev_i(rise_ev), .fall_ev_i(fall_ev),
    .clr_i(clr), .rise_q(rise_q), .fall_q(fall_q)
  );

  gio_trig_view #(.N(N)) u_view (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(reg_wdata),
    .rise_q(rise_q), .fall_q(fall_q), .cfg_q(cfg_q), .vis_o(vis),
    .irq_q(irq_o)
  );

  always_comb begin
    case (ra)
      RA_LEVEL: reg_rdata = {{(DW-N){1'b0}}, level};
      RA_TRIG:  reg_rdata = cfg_q;
      RA_STAT:  reg_rdata = {{(DW-N){1'b0}}, vis};
      default:  reg_rdata = '0;
    endcase
  end

  // R8: the parent line is only ever raised by a latched flag
  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(rise_q | fall_q)));
endmodule

// File: tb/sim_gio_edge_irq.sv
module sim_gio_edge_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin_i = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gio_edge_irq u0 (
    .clk(clk), .rst(rst), .pin_i(pin_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    rd(2'd2, v); chk("R1 status", v, 16'h0);
    rd(2'd1, v); chk("R1 trig", v, 16'h0);
    rd(2'd3, v); chk("R1 spare", v, 16'h0);
    chk("R1 irq", {15'b0, irq_o}, 16'h0);

    // R2: level latency, pins change just before edge k
    pin_i = 8'hA5;
    @(negedge clk);                    // after edge k
    rd(2'd0, v); chk("R2 level early", v, 16'h0000);
    @(negedge clk);                    // after edge k+1
    rd(2'd0, v); chk("R2 level", v, 16'h00A5);
    pin_i = 8'h00;
    settle();
    rd(2'd0, v); chk("R2 level low", v, 16'h0000);

    // R10: writes to level/spare ignored, trig reads back
    wr(2'd2, 16'hFFFF);
    wr(2'd1, 16'h1234);
    wr(2'd0, 16'hFFFF);
    wr(2'd3, 16'hFFFF);
    rd(2'd1, v); chk("R10 trig readback", v, 16'h1234);
    rd(2'd0, v); chk("R10 level untouched", v, 16'h0000);
    rd(2'd2, v); chk("R10 status untouched", v, 16'h0000);

    // R3 R4 R5 R9: sweep pin x code x direction
    for (int i = 0; i < 8; i++) begin
      for (int code = 0; code < 4; code++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic [15:0] one, expv;
          bit rising;
          rising = (dir == 0);
          one = 16'(1) << i;
          pin_i[i] = rising ? 1'b0 : 1'b1;
          settle();
          wr(2'd2, 16'hFFFF);
          wr(2'd1, 16'(code) << (2 * i));
          pin_i[i] = rising ? 1'b1 : 1'b0;
          settle();
          expv = ((code == 2 && rising) || (code == 1 && !rising)) ? one : 16'h0;
          rd(2'd2, v);
          chk(rising ? "R3 R5 rise view" : "R4 R5 fall view", v, expv);
          chk("R8 irq sweep", {15'b0, irq_o}, (expv != 0) ? 16'h1 : 16'h0);
          wr(2'd1, (rising ? 16'd2 : 16'd1) << (2 * i));
          rd(2'd2, v);
          chk("R9 latched edge visible", v, one);
          @(negedge clk);
          chk("R9 irq after switch", {15'b0, irq_o}, 16'h1);
        end
      end
      pin_i[i] = 1'b0;
      settle();
    end

    // R6: partial W1C clears both flags of selected bits
    wr(2'd2, 16'hFFFF);
    pin_i = 8'hFF; settle();
    pin_i = 8'h00; settle();
    wr(2'd1, 16'hAAAA);
    rd(2'd2, v); chk("R6 all rise set", v, 16'h00FF);
    wr(2'd2, 16'h000F);
    rd(2'd2, v); chk("R6 rise partial clear", v, 16'h00F0);
    wr(2'd1, 16'h5555);
    rd(2'd2, v); chk("R6 fall partial clear", v, 16'h00F0);
    wr(2'd1, 16'hFFFF);
    rd(2'd2, v); chk("R5 code 11 hides", v, 16'h0000);
    wr(2'd1, 16'h0000);
    rd(2'd2, v); chk("R5 code 00 hides", v, 16'h0000);

    // R8: exact irq timing on pin 0
    wr(2'd2, 16'hFFFF);
    wr(2'd1, 16'h0002);
    @(negedge clk);
    pin_i[0] = 1'b1;                   // before edge k
    @(negedge clk); @(negedge clk); @(negedge clk);   // after k+2
    rd(2'd2, v); chk("R8 status at k+2", v, 16'h0001);
    chk("R8 irq not yet", {15'b0, irq_o}, 16'h0);
    @(negedge clk);                    // after k+3
    chk("R8 irq raised", {15'b0, irq_o}, 16'h1);
    wr(2'd2, 16'h0001);
    @(negedge clk);
    chk("R8 irq dropped", {15'b0, irq_o}, 16'h0);

    // R7: rising edge on pin 0 meets clear in same cycle
    pin_i[0] = 1'b0; settle();         // falling flag set
    pin_i[0] = 1'b1; settle();         // rising flag set too
    pin_i[0] = 1'b0; settle();
    wr(2'd1, 16'h0001);
    rd(2'd2, v); chk("R7 fall flag pre", v, 16'h0001);
    pin_i[0] = 1'b1;                   // before edge k
    @(negedge clk);                    // after k
    @(negedge clk);                    // after k+1
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0001;
    @(negedge clk);                    // after k+2: edge and clear together
    reg_we = 1'b0; reg_wdata = '0;
    rd(2'd2, v); chk("R7 fall flag cleared", v, 16'h0000);
    wr(2'd1, 16'h0002);
    rd(2'd2, v); chk("R7 rise flag survives", v, 16'h0001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule